// File: doc/BRIEF.md
# Wide Dual-Read Memory Adapter

This block presents a 256-entry store of 64-bit words with two access points. Port A can write a full word and can read; port B reads only, and both reads may be served in the same clock cycle, at the same address or at different ones. Internally the word is split into two 32-bit lanes. Each lane lives in its own bank, which has one read-write port and one read-only port. A write updates both banks at one address in a single cycle, and the lane outputs are concatenated back into a 64-bit result.

All reads are synchronous. The address is taken at a clock edge, and the data is held in an output register that the consumer sees from the following cycle. A consumer must therefore schedule one cycle of read latency. Because of this the adapter behaves exactly like storage built from synchronous-read macros. Each read port has its own enable; while that enable is low, the port's output register keeps its last value. The stored words have no reset and are defined only after they have been written. The output registers clear to zero on reset.

Top module: `wide_dual_read_mem`

## Requirements
- R1: While reset (active-low `rst_n`) is asserted, and in the first cycle after it is released, `a_rdata` and `b_rdata` are zero.
- R2: When `a_en` is high at a clock edge, `a_rdata` shows the word stored at `a_addr` from that edge until the next edge at which the port loads again (one cycle of latency).
- R3: Port B returns the word stored at `b_addr` one cycle after an edge with `b_en` high, independently of port A and in the same cycle as a port A read.
- R4: A write (`a_we` high) stores all 64 bits of `a_wdata` at `a_addr` in one edge: bits [31:0] go to the low bank and bits [63:32] to the high bank, and a later read returns both halves unchanged.
- R5: When port A writes and reads the same address at one edge, `a_rdata` returns the contents from before the write.
- R6: When port B reads the address that port A writes at the same edge, `b_rdata` returns the contents from before the write.
- R7: While a port's enable is low, its read-data output holds its previous value, whatever its address input does.
- R8: A write with `a_en` low updates the store but leaves `a_rdata` unchanged.
- R9: When both ports read the same address at one edge, both outputs carry the same word in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low reset of the read-data registers |
| a_en | input | 1 | Port A read enable |
| a_we | input | 1 | Port A write enable (full 64-bit word) |
| a_addr | input | 8 | Port A word address |
| a_wdata | input | 64 | Port A write data |
| a_rdata | output | 64 | Port A read data, one cycle after the request |
| b_en | input | 1 | Port B read enable |
| b_addr | input | 8 | Port B word address |
| b_rdata | output | 64 | Port B read data, one cycle after the request |

## Verification
The hardest case to reach is a collision: port A writing an address that port A and/or port B read at the same edge. In that case the correct answer is the old word, and it is visible only if the old and new values differ in both halves. The bench first fills every entry with a distinct address-derived pattern. It then runs directed collisions in which the new word differs from the old one in every bit of each lane. A long random phase follows, with addresses drawn from a narrow window so that write/read and read/read overlaps occur often. A scoreboard predicts each output from a reference array that is updated only after the expected value has been captured.

// File: rtl/wdr_pkg.sv
package wdr_pkg;

    // Default geometry of the adapter and of its banks
    localparam int WDR_DEPTH  = 256;
    localparam int WDR_DATA_W = 64;
    localparam int WDR_BANK_W = 32;

    // Number of banks that make up one logical word
    function automatic int wdr_lanes(input int data_w, input int bank_w);
        return data_w / bank_w;
    endfunction

endpackage

// File: rtl/wdr_rdport.sv
// Read output register: loads the addressed word on enable, holds otherwise.
module wdr_rdport #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [WIDTH-1:0] word,
    output logic [WIDTH-1:0] q
);

    typedef struct packed {
        logic [WIDTH-1:0] data;
    } rd_state_t;

    rd_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en) begin
            st_d.data = word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.data;

endmodule

// File: rtl/wdr_bank.sv
// Behavioural bank: one read-write port, one read-only port, synchronous
// reads, old data returned on a same-edge write/read collision.
module wdr_bank #(
    parameter int DEPTH  = 256,
    parameter int WIDTH  = 32,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rw_en,
    input  logic              rw_we,
    input  logic [ADDR_W-1:0] rw_addr,
    input  logic [WIDTH-1:0]  rw_wdata,
    output logic [WIDTH-1:0]  rw_rdata,
    input  logic              ro_en,
    input  logic [ADDR_W-1:0] ro_addr,
    output logic [WIDTH-1:0]  ro_rdata
);

    logic [WIDTH-1:0] store_q [DEPTH];
    logic [WIDTH-1:0] rw_word_d;
    logic [WIDTH-1:0] ro_word_d;

    // Array write: the output registers sample the pre-write contents
    always_ff @(posedge clk) begin
        if (rw_we) begin
            store_q[rw_addr] <= rw_wdata;
        end
    end

    always_comb begin
        rw_word_d = store_q[rw_addr];
        ro_word_d = store_q[ro_addr];
    end

    wdr_rdport #(.WIDTH(WIDTH)) u_rw_out (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (rw_en),
        .word  (rw_word_d),
        .q     (rw_rdata)
    );

    wdr_rdport #(.WIDTH(WIDTH)) u_ro_out (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ro_en),
        .word  (ro_word_d),
        .q     (ro_rdata)
    );

endmodule

// File: rtl/wide_dual_read_mem.sv
// 64-bit, two-read-port store assembled from 32-bit 1RW+1R banks.
module wide_dual_read_mem #(
    parameter int DEPTH  = wdr_pkg::WDR_DEPTH,
    parameter int DATA_W = wdr_pkg::WDR_DATA_W,
    parameter int BANK_W = wdr_pkg::WDR_BANK_W,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_en,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    input  logic              b_en,
    input  logic [ADDR_W-1:0] b_addr,
    output logic [DATA_W-1:0] b_rdata
);

    localparam int LANES = wdr_pkg::wdr_lanes(DATA_W, BANK_W);

    // One bank per lane; every bank sees the same control and address
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        wdr_bank #(
            .DEPTH  (DEPTH),
            .WIDTH  (BANK_W),
            .ADDR_W (ADDR_W)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .rw_en    (a_en),
            .rw_we    (a_we),
            .rw_addr  (a_addr),
            .rw_wdata (a_wdata[g*BANK_W +: BANK_W]),
            .rw_rdata (a_rdata[g*BANK_W +: BANK_W]),
            .ro_en    (b_en),
            .ro_addr  (b_addr),
            .ro_rdata (b_rdata[g*BANK_W +: BANK_W])
        );
    end

endmodule

// File: rtl/wdr_checker.sv
module wdr_checker #(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              a_en,
    input logic              a_we,
    input logic [ADDR_W-1:0] a_addr,
    input logic [DATA_W-1:0] a_rdata,
    input logic              b_en,
    input logic [ADDR_W-1:0] b_addr,
    input logic [DATA_W-1:0] b_rdata
);

    // R1: outputs are clear in the first cycle out of reset
    a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (a_rdata == '0 && b_rdata == '0));

    // R7: port A holds while its enable is low
    a_r7_hold_a: assert property (@(posedge clk) disable iff (!rst_n)
        !a_en |=> $stable(a_rdata));

    // R7: port B holds while its enable is low
    a_r7_hold_b: assert property (@(posedge clk) disable iff (!rst_n)
        !b_en |=> $stable(b_rdata));

    // R8: a write without read enable leaves port A output untouched
    a_r8_write_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (a_we && !a_en) |=> $stable(a_rdata));

    // R9: same-address reads on both ports agree
    a_r9_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en && b_en && a_addr == b_addr) |=> (a_rdata == b_rdata));

endmodule

bind wide_dual_read_mem wdr_checker #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_en    (a_en),
    .a_we    (a_we),
    .a_addr  (a_addr),
    .a_rdata (a_rdata),
    .b_en    (b_en),
    .b_addr  (b_addr),
    .b_rdata (b_rdata)
);

// File: tb/sim_wide_dual_read_mem.sv
module sim_wide_dual_read_mem;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 256;
    localparam int DW         = 64;
    localparam int AW         = 8;

    typedef struct {
        logic [DW-1:0] val;
        string         req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          a_en = 1'b0;
    logic          a_we = 1'b0;
    logic [AW-1:0] a_addr = '0;
    logic [DW-1:0] a_wdata = '0;
    logic [DW-1:0] a_rdata;
    logic          b_en = 1'b0;
    logic [AW-1:0] b_addr = '0;
    logic [DW-1:0] b_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [DW-1:0] ref_mem [DEPTH];
    logic [DW-1:0] hold_a = '0;
    logic [DW-1:0] hold_b = '0;
    exp_t qa[$];
    exp_t qb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    wide_dual_read_mem u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_en    (a_en),
        .a_we    (a_we),
        .a_addr  (a_addr),
        .a_wdata (a_wdata),
        .a_rdata (a_rdata),
        .b_en    (b_en),
        .b_addr  (b_addr),
        .b_rdata (b_rdata)
    );

    task automatic check(input string req, input string port,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s port %s actual %h expected %h", req, port, act, exp);
        end
    endtask

    // Driver: applies one cycle of stimulus and pushes the predicted outputs
    task automatic drive(input bit ae, input bit we, input logic [AW-1:0] aa,
                         input logic [DW-1:0] wd, input bit be,
                         input logic [AW-1:0] ba, input string ra, input string rb);
        exp_t ea;
        exp_t eb;
        @(negedge clk);
        a_en = ae; a_we = we; a_addr = aa; a_wdata = wd;
        b_en = be; b_addr = ba;
        if (ae) hold_a = ref_mem[aa];
        if (be) hold_b = ref_mem[ba];
        if (we) ref_mem[aa] = wd;
        ea.val = hold_a; ea.req = ra;
        eb.val = hold_b; eb.req = rb;
        qa.push_back(ea);
        qb.push_back(eb);
    endtask

    // Monitor: compares the outputs one quarter period after each edge
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (rst_n && qa.size() > 0) begin
                exp_t e;
                e = qa.pop_front();
                check(e.req, "A", a_rdata, e.val);
            end
            if (rst_n && qb.size() > 0) begin
                exp_t e;
                e = qb.pop_front();
                check(e.req, "B", b_rdata, e.val);
            end
        end
    end

    function automatic logic [DW-1:0] pat(input int a);
        return {8'hC3, 8'(a), 16'h1357, 8'h5A, 8'(~a), 16'h2468};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs are zero during reset
        check("R1", "A", a_rdata, '0);
        check("R1", "B", b_rdata, '0);
        rst_n = 1'b1;
        // R1: idle cycle right after release still shows zero
        drive(0, 0, 0, 0, 0, 0, "R1", "R1");

        // R8: fill every entry with reads disabled; outputs must stay zero
        for (int i = 0; i < DEPTH; i++) begin
            drive(0, 1, AW'(i), pat(i), 0, 0, "R8", "R7");
        end

        // R2: sequential port A reads
        for (int i = 0; i < 8; i++) drive(1, 0, AW'(i * 3), 0, 0, 0, "R2", "R7");

        // R3: concurrent reads at distinct addresses
        for (int i = 0; i < 8; i++)
            drive(1, 0, AW'(i), 0, 1, AW'(255 - i), "R3", "R3");

        // R4: full-word write, halves with distinct patterns, then read back
        drive(0, 1, 8'd10, 64'hAAAA5555_0F0F1234, 0, 0, "R8", "R7");
        drive(1, 0, 8'd10, 0, 1, 8'd10, "R4", "R4");
        drive(0, 1, 8'd10, 64'h0000FFFF_FFFF0000, 0, 0, "R8", "R7");
        drive(1, 0, 8'd10, 0, 1, 8'd10, "R4", "R4");

        // R5: port A write and read at one address returns old word
        drive(1, 1, 8'd20, ~pat(20), 0, 0, "R5", "R7");
        drive(1, 0, 8'd20, 0, 0, 0, "R4", "R7");

        // R6: port B reads the address port A writes
        drive(0, 1, 8'd30, ~pat(30), 1, 8'd30, "R8", "R6");
        drive(0, 0, 0, 0, 1, 8'd30, "R7", "R6");

        // R5, R6, R9: triple collision
        drive(1, 1, 8'd40, ~pat(40), 1, 8'd40, "R5", "R6");
        drive(1, 0, 8'd40, 0, 1, 8'd40, "R9", "R9");

        // R7: enables low while addresses wander
        for (int i = 0; i < 6; i++)
            drive(0, 0, AW'(i + 50), 0, 0, AW'(i + 90), "R7", "R7");

        // R9: both ports on one address
        for (int i = 0; i < 4; i++)
            drive(1, 0, AW'(i * 17), 0, 1, AW'(i * 17), "R9", "R9");

        // R3: random concurrent traffic in a narrow address window
        for (int i = 0; i < 3000; i++) begin
            logic [AW-1:0] ra;
            logic [AW-1:0] rb;
            ra = AW'($urandom_range(0, 7));
            rb = AW'($urandom_range(0, 7));
            drive(1'($urandom), 1'($urandom), ra, {$urandom, $urandom},
                  1'($urandom), rb, "R3", "R3");
        end

        drive(0, 0, 0, 0, 0, 0, "R7", "R7");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule